// File: doc/BRIEF.md
# Multiplexed Pixel Word Demultiplexer

This block sits behind a narrow 12-bit pixel port fed by a graphics source. The source sends each pixel as two words in turn: word a, then word b. The block collects each pair and puts out one 24-bit pixel together with a one-cycle valid pulse. A 3-bit format code chooses how the pixel fields are spread over the two words. There are two 24-bit RGB layouts that use all 12 bits. There are two 16-bit RGB layouts, 565 and 555, and one luma/chroma layout. These last three use only the low 8 bits of each word.

Word capture is modelled as a single-edge stream at twice the pixel rate. Each cycle with the word strobe high delivers one word. When the dual-word input is high, the source has already captured both halves of a pixel on the two edges of a pixel-rate clock. In that case each strobed cycle carries word a on `word_i` and word b on `word2_i`.

Pair alignment is restarted from horizontal sync. A word that arrives in the first cycle in which `hsync_i` is seen high is always taken as word a. Any word a still waiting for its partner is dropped at that point.

Top module: `pix_word_demux`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pix_vld_o` is low.
- R2: In single-word mode, every second strobed word (word b) causes `pix_vld_o` to pulse for exactly one cycle, in the cycle after word b is presented. Cycles with `word_vld_i` low are skipped and do not break the pairing.
- R3: A cycle in which `hsync_i` is high after being low in the previous cycle resets the pair phase. A word strobed in that cycle becomes word a. A word a that was waiting beforehand never produces a pixel.
- R4: Format 0: word a = {G[3:0], B[7:0]} and word b = {R[7:0], G[7:4]}, most significant bit first. The output is `pix_o` = {R, G, B}, with R in bits 23:16.
- R5: Format 1: word a = {G[2:0], B[7:0], G[3]} and word b = {R[7:0], G[7:4]}. The output is `pix_o` = {R, G, B}.
- R6: Format 2 (565): the 16-bit value {b[7:0], a[7:0]} holds R5 in bits 15:11, G6 in bits 10:5 and B5 in bits 4:0. Each field is widened to 8 bits by copying its top bits into the low bits.
- R7: Format 3 (555): the 16-bit value {b[7:0], a[7:0]} holds R5 in bits 14:10, G5 in bits 9:5 and B5 in bits 4:0, with bit 15 ignored. Fields are widened as in R6. In formats 2, 3 and 4, word bits 11:8 have no effect.
- R8: Format 4 (luma/chroma): pairs alternate, starting with (Cb, Y) and then (Cr, Y), using the low bytes of word a and word b. The output is `pix_o` = {Y, Cb, Cr}, holding the most recent Cb and Cr. The alternation restarts at Cb on each hsync leading edge, and the held Cb and Cr are then reset to 128.
- R9: Format codes 5, 6 and 7 produce no pixels, and they clear any waiting word a.
- R10: In dual-word mode, each strobed cycle with a valid format produces a pixel in the next cycle. `word_i` is used as word a and `word2_i` as word b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 12 | Captured word (word a in dual-word mode) |
| word2_i | input | 12 | Second captured word, used only in dual-word mode |
| word_vld_i | input | 1 | Strobe: the word(s) on the inputs are valid this cycle |
| dual_i | input | 1 | 1 = both words of a pixel arrive in one cycle |
| hsync_i | input | 1 | Horizontal sync, active high |
| fmt_i | input | 3 | Packing format code (0 to 4 valid) |
| pix_o | output | 24 | Assembled pixel |
| pix_vld_o | output | 1 | One-cycle pulse marking a new pixel on `pix_o` |

## Verification
The assertions assume that `fmt_i` and `dual_i` are steady while a pixel is being assembled. They also assume that hsync is a level that the block samples each cycle, not a pulse narrower than one cycle. The stimulus changes format and mode only between pixels, with two exceptions: deliberate switches to a reserved code with a word a pending, and sync edges placed in the middle of a pair. Sync pulses are always held high for at least one cycle and low for at least one cycle before the next rise. The words themselves are random 12-bit values, so the upper bits that the 8-bit formats must ignore are exercised.

// File: rtl/pix_word_demux.sv
module pix_word_demux #(
  parameter int WW = 12,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] word_i,
  input  logic [WW-1:0] word2_i,
  input  logic          word_vld_i,
  input  logic          dual_i,
  input  logic          hsync_i,
  input  logic [2:0]    fmt_i,
  output logic [PW-1:0] pix_o,
  output logic          pix_vld_o
);

  localparam logic [2:0] FMT_MAX = 3'd4;
  localparam logic [7:0] CHROMA_MID = 8'd128;

  logic          hs_q, have_a, cph;
  logic [WW-1:0] a_q;
  logic [7:0]    cb_q, cr_q, cb_n, cr_n;
  logic [PW-1:0] pix_d;
  logic [4:0]    r5, b5, g5;
  logic [5:0]    g6;

  wire          hs_rise = hsync_i & ~hs_q;
  wire          fmt_ok  = fmt_i <= FMT_MAX;
  wire [WW-1:0] wa      = dual_i ? word_i  : a_q;
  wire [WW-1:0] wb      = dual_i ? word2_i : word_i;
  wire          fire    = fmt_ok & word_vld_i & (dual_i | (have_a & ~hs_rise));
  wire          cph_eff = hs_rise ? 1'b0 : cph;
  wire [7:0]    cb_eff  = hs_rise ? CHROMA_MID : cb_q;
  wire [7:0]    cr_eff  = hs_rise ? CHROMA_MID : cr_q;
  wire [15:0]   v16     = {wb[7:0], wa[7:0]};

  always_comb begin
    cb_n  = cph_eff ? cb_eff : wa[7:0];
    cr_n  = cph_eff ? wa[7:0] : cr_eff;
    r5    = 5'd0;
    g5    = 5'd0;
    g6    = 6'd0;
    b5    = 5'd0;
    pix_d = '0;
    case (fmt_i)
      3'd0: pix_d = {wb[11:4], wb[3:0], wa[11:8], wa[7:0]};
      3'd1: pix_d = {wb[11:4], wb[3:0], wa[0], wa[11:9], wa[8:1]};
      3'd2: begin
        r5    = v16[15:11];
        g6    = v16[10:5];
        b5    = v16[4:0];
        pix_d = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
      end
      3'd3: begin
        r5    = v16[14:10];
        g5    = v16[9:5];
        b5    = v16[4:0];
        pix_d = {r5, r5[4:2], g5, g5[4:2], b5, b5[4:2]};
      end
      3'd4: pix_d = {wb[7:0], cb_n, cr_n};
      default: pix_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q      <= 1'b0;
      have_a    <= 1'b0;
      a_q       <= '0;
      cph       <= 1'b0;
      cb_q      <= CHROMA_MID;
      cr_q      <= CHROMA_MID;
      pix_o     <= '0;
      pix_vld_o <= 1'b0;
    end else begin
      hs_q      <= hsync_i;
      pix_vld_o <= fire;
      if (fire) pix_o <= pix_d;

      if (!fmt_ok || (hs_rise && !word_vld_i) || (word_vld_i && dual_i))
        have_a <= 1'b0;
      else if (word_vld_i) begin
        if (have_a && !hs_rise) have_a <= 1'b0;
        else begin
          have_a <= 1'b1;
          a_q    <= word_i;
        end
      end

      if (fire && fmt_i == FMT_MAX) begin
        cph  <= ~cph_eff;
        cb_q <= cb_n;
        cr_q <= cr_n;
      end else if (hs_rise) begin
        cph  <= 1'b0;
        cb_q <= CHROMA_MID;
        cr_q <= CHROMA_MID;
      end
    end
  end

  // R9
  reserved_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_o |-> ($past(fmt_i) <= FMT_MAX));

  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_o |-> $past(word_vld_i));

  // R3
  rephase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_i && !hs_q && word_vld_i && !dual_i) |=> !pix_vld_o);

  // R10
  dual_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && dual_i && fmt_i <= FMT_MAX) |=> pix_vld_o);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !pix_vld_o);

endmodule

// File: tb/pix_word_demux_tb.sv
module pix_word_demux_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] word_i = 0, word2_i = 0;
  logic        word_vld_i = 0, dual_i = 0, hsync_i = 0;
  logic [2:0]  fmt_i = 0;
  logic [23:0] pix_o;
  logic        pix_vld_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // model state
  int m_prev_hs = 0, m_have_a = 0, m_a = 0, m_cph = 0, m_cb = 128, m_cr = 128;
  int e_vld = 0, e_pix = 0;

  always #10 clk = ~clk;

  pix_word_demux dut_i (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word2_i(word2_i),
    .word_vld_i(word_vld_i), .dual_i(dual_i), .hsync_i(hsync_i),
    .fmt_i(fmt_i), .pix_o(pix_o), .pix_vld_o(pix_vld_o));

  function automatic int wide5(int x); return (x << 3) | (x >> 2); endfunction

  task automatic emit(int a, int b, int f);
    int r, g, bl, v;
    v = ((b & 255) << 8) | (a & 255);
    case (f)
      0: begin r = b >> 4; g = ((b & 15) << 4) | (a >> 8); bl = a & 255; end
      1: begin r = b >> 4; g = ((b & 15) << 4) | ((a & 1) << 3) | (a >> 9); bl = (a >> 1) & 255; end
      2: begin r = wide5(v >> 11); g = (((v >> 5) & 63) << 2) | (((v >> 5) & 63) >> 4); bl = wide5(v & 31); end
      3: begin r = wide5((v >> 10) & 31); g = wide5((v >> 5) & 31); bl = wide5(v & 31); end
      default: begin
        if (m_cph == 0) m_cb = a & 255; else m_cr = a & 255;
        m_cph ^= 1;
        r = b & 255; g = m_cb; bl = m_cr;
      end
    endcase
    e_vld = 1;
    e_pix = (r << 16) | (g << 8) | bl;
  endtask

  task automatic model();
    int rise;
    rise = (hsync_i && !m_prev_hs) ? 1 : 0;
    m_prev_hs = hsync_i;
    e_vld = 0;
    if (rise) begin m_have_a = 0; m_cph = 0; m_cb = 128; m_cr = 128; end
    if (fmt_i > 4) m_have_a = 0;
    else if (word_vld_i) begin
      if (dual_i) begin m_have_a = 0; emit(word_i, word2_i, fmt_i); end
      else if (!m_have_a) begin m_a = word_i; m_have_a = 1; end
      else begin m_have_a = 0; emit(m_a, word_i, fmt_i); end
    end
  endtask

  task automatic cyc(input bit v, input bit hs, input string tag);
    word_vld_i = v;
    hsync_i    = hs;
    word_i     = 12'($urandom);
    word2_i    = 12'($urandom);
    model();
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (pix_vld_o !== e_vld[0]) begin
      n_bad++;
      $display("FAIL %s: pix_vld_o=%0b expected %0b", tag, pix_vld_o, e_vld[0]);
    end else if (e_vld != 0 && pix_o !== e_pix[23:0]) begin
      n_bad++;
      $display("FAIL %s: pix_o=%06h expected %06h", tag, pix_o, e_pix[23:0]);
    end
  endtask

  function automatic string ftag(int f);
    case (f)
      0: return "R4"; 1: return "R5"; 2: return "R6"; 3: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (pix_vld_o !== 1'b0) begin
      n_bad++; $display("FAIL R1: pix_vld_o=%0b expected 0", pix_vld_o);
    end
    rst_n = 1;
    cyc(0, 0, "R1");
    for (int f = 0; f < 5; f++) begin
      fmt_i = 3'(f);
      cyc(0, 0, ftag(f));
      cyc(1, 1, "R3");
      cyc(1, 1, ftag(f));
      for (int k = 0; k < 8; k++) cyc(1, 0, ftag(f));
      cyc(1, 0, "R2");
      cyc(0, 0, "R2");
      cyc(0, 0, "R2");
      cyc(1, 0, "R2");
      cyc(1, 0, "R3");
      cyc(1, 1, "R3");
      cyc(1, 1, "R3");
      cyc(1, 0, "R3");
      cyc(0, 0, "R3");
      cyc(1, 1, "R3");
      cyc(0, 0, "R3");
      for (int k = 0; k < 6; k++) cyc(1, 0, ftag(f));
    end
    fmt_i = 3'd2;
    cyc(1, 0, "R9");
    for (int f = 5; f < 8; f++) begin
      fmt_i = 3'(f);
      for (int k = 0; k < 3; k++) cyc(1, 0, "R9");
    end
    fmt_i = 3'd0;
    cyc(1, 0, "R9");
    cyc(1, 0, "R9");
    cyc(1, 0, "R9");
    cyc(0, 0, "R9");
    dual_i = 1;
    for (int f = 0; f < 5; f++) begin
      fmt_i = 3'(f);
      cyc(1, 1, "R10");
      cyc(1, 1, "R10");
      cyc(0, 0, "R10");
      for (int k = 0; k < 5; k++) cyc(1, 0, "R10");
    end
    dual_i = 0;
    fmt_i = 3'd4;
    cyc(1, 0, "R8");
    cyc(1, 1, "R8");
    for (int k = 0; k < 6; k++) cyc(1, 1, "R8");
    cyc(0, 0, "R8");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule